// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one integer by another over several clock cycles and returns either the quotient or the remainder. A mode input selects which one. The dividend has WA bits and the divisor has WB bits. Both are widened to one common working width W, the largest of WA, WB and WY. Each operand has its own signedness flag. Arithmetic is signed only when both flags are set. In every other case both operands are read as unsigned.

A caller raises `start` for one cycle while `busy` is low. The operands, flags and mode are captured at that edge. The block then works out one quotient bit per cycle, most significant bit first, by restoring subtraction on operand magnitudes. In the signed case it corrects the signs at the end. A one-cycle `done` pulse marks a valid `result`, and the result holds until the next pulse.

A zero divisor is not an error. It produces fixed results that depend on the mode, the signedness and the operand widths, and it takes exactly as long as any other operation.

Top module: `seq_divider`

## Requirements
- R1: Signed arithmetic is used only when `a_signed` and `b_signed` are both 1. Otherwise both operands are zero-extended to W bits and treated as unsigned. In signed arithmetic both operands are sign-extended.
- R2: In unsigned arithmetic with a nonzero divisor, `result` is the low WY bits of floor(A/B) when `want_rem`=0, and of A mod B when `want_rem`=1.
- R3: In signed arithmetic with a nonzero divisor, the quotient is |A|/|B| rounded toward zero and negated when the operand signs differ. The remainder has the magnitude |A| mod |B| and takes the sign of the dividend. Both are reported as their low WY bits in two's complement.
- R4: Quotient bits are formed from the most significant bit down by a compare-and-subtract of the divisor against the partial remainder. After every step the partial remainder stays below a nonzero divisor.
- R5: An unsigned quotient with a zero divisor (all divisor bits clear) has its low WA bits set to 1 and every higher bit clear.
- R6: A signed quotient with a zero divisor is all ones when the dividend is zero or positive, and is the value 1 when the dividend is negative.
- R7: A remainder with a zero divisor equals the low min(WA,WB) bits of the dividend. These bits are sign-extended from the top copied bit in signed arithmetic and zero-extended otherwise, then cut to WY bits.
- R8: `done` rises exactly W+1 clock edges after the edge that accepted `start`, for every operand value including a zero divisor. `busy` is 1 from the accepting edge until the edge that raises `done`, and is 0 while `done` is 1.
- R9: `done` is a single-cycle pulse. `result` does not change in any cycle where `done` is 0.
- R10: A `start` while `busy` is 1 is ignored. Operands, flags and mode are sampled only at an accepted start, so later changes on those inputs do not alter the pending result.
- R11: After reset, `busy`, `done` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new operation; accepted only when idle |
| a_signed | input | 1 | Dividend signedness flag |
| b_signed | input | 1 | Divisor signedness flag |
| want_rem | input | 1 | 0 selects the quotient, 1 selects the remainder |
| a_in | input | WA | Dividend |
| b_in | input | WB | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| result | output | WY | Quotient or remainder, held between pulses |

## Verification
The bench builds the block with WA=4, WB=4 and WY=6, so the working width is 6.

Because WY is wider than WA, the cleared upper bits of the unsigned zero-divisor quotient and the sign extension of the zero-divisor remainder become visible. These widths also allow an exhaustive sweep of every dividend/divisor pair. The sweep runs in unsigned, signed and mixed-flag arithmetic, in both modes, and it includes the most negative dividend divided by minus one.

On some operations the bench also raises a second start mid-run with altered operands. It then checks that the pending result is not disturbed and that it holds after the pulse.

// File: rtl/div_pkg.sv
package div_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2
   } div_state_e;

   function automatic int min2(input int x, input int y);
      return (x < y) ? x : y;
   endfunction

   function automatic int max3(input int x, input int y, input int z);
      int m;
      m = (x > y) ? x : y;
      return (m > z) ? m : z;
   endfunction

endpackage

// File: rtl/div_operand_prep.sv
// Widens both operands to the working width and forms their magnitudes.
module div_operand_prep #(
   parameter int WA = 8,
   parameter int WB = 8,
   parameter int W  = 8
) (
   input  logic [WA-1:0] a_in,
   input  logic [WB-1:0] b_in,
   input  logic          a_sgn,
   input  logic          b_sgn,
   output logic          signed_mode,
   output logic          a_neg,
   output logic          b_neg,
   output logic          b_zero,
   output logic [W-1:0]  a_mag,
   output logic [W-1:0]  b_mag
);

   logic [W-1:0] a_ext;
   logic [W-1:0] b_ext;

   // R1: both flags needed for signed arithmetic
   assign signed_mode = a_sgn & b_sgn;
   assign a_neg       = signed_mode & a_in[WA-1];
   assign b_neg       = signed_mode & b_in[WB-1];
   assign b_zero      = (b_in == '0);

   generate
      if (W > WA) begin : g_a_wide
         assign a_ext = {{(W-WA){a_neg}}, a_in};
      end else begin : g_a_fit
         assign a_ext = a_in;
      end
      if (W > WB) begin : g_b_wide
         assign b_ext = {{(W-WB){b_neg}}, b_in};
      end else begin : g_b_fit
         assign b_ext = b_in;
      end
   endgenerate

   assign a_mag = a_neg ? (~a_ext + 1'b1) : a_ext;
   assign b_mag = b_neg ? (~b_ext + 1'b1) : b_ext;

endmodule

// File: rtl/div_restore_core.sv
// One restoring step per cycle on unsigned magnitudes, MSB first.
module div_restore_core #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);

   logic [W-1:0] rem_q;
   logic [W-1:0] quo_q;
   logic [W-1:0] dvs_q;
   logic [W:0]   partial;
   logic [W+1:0] trial;
   logic         fits;

   // bring down the next dividend bit, then try the subtraction
   assign partial = {rem_q, quo_q[W-1]};
   assign trial   = {1'b0, partial} - {2'b00, dvs_q};
   assign fits    = ~trial[W+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         dvs_q <= '0;
      end else if (load) begin
         rem_q <= '0;
         quo_q <= dividend;
         dvs_q <= divisor;
      end else if (step) begin
         rem_q <= fits ? trial[W-1:0] : partial[W-1:0];
         quo_q <= {quo_q[W-2:0], fits};
      end
   end

   assign quo = quo_q;
   assign rem = rem_q;

   assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dvs_q != '0) |-> (rem_q < dvs_q));

endmodule

// File: rtl/div_result_fix.sv
// Sign correction, width adaptation and the zero-divisor substitutes.
module div_result_fix #(
   parameter int WA = 8,
   parameter int WY = 8,
   parameter int W  = 8,
   parameter int KM = 8
) (
   input  logic [W-1:0]  quo_mag,
   input  logic [W-1:0]  rem_mag,
   input  logic          want_rem,
   input  logic          signed_mode,
   input  logic          a_neg,
   input  logic          b_neg,
   input  logic          b_zero,
   input  logic [KM-1:0] a_low,
   output logic [WY-1:0] res
);

   logic [WY-1:0] q_t, r_t, q_s, r_s;
   logic [WY-1:0] udz, sdz, mdz;

   assign q_t = quo_mag[WY-1:0];
   assign r_t = rem_mag[WY-1:0];
   assign q_s = (a_neg ^ b_neg) ? (~q_t + 1'b1) : q_t;   // R3
   assign r_s = a_neg ? (~r_t + 1'b1) : r_t;

   // R5: ones in the dividend's width, zeros above
   generate
      for (genvar i = 0; i < WY; i++) begin : g_udz
         assign udz[i] = (i < WA);
      end
      // R7: copied dividend bits, extended per signedness
      if (WY > KM) begin : g_mz_ext
         assign mdz = {{(WY-KM){signed_mode & a_low[KM-1]}}, a_low};
      end else begin : g_mz_fit
         assign mdz = a_low;
      end
   endgenerate

   // R6
   assign sdz = a_neg ? WY'(1) : '1;

   always_comb begin
      if (b_zero) begin
         if (want_rem)         res = mdz;
         else if (signed_mode) res = sdz;
         else                  res = udz;
      end else begin
         res = want_rem ? r_s : q_s;
      end
   end

endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
   parameter int WA = 8,
   parameter int WB = 8,
   parameter int WY = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          a_signed,
   input  logic          b_signed,
   input  logic          want_rem,
   input  logic [WA-1:0] a_in,
   input  logic [WB-1:0] b_in,
   output logic          busy,
   output logic          done,
   output logic [WY-1:0] result
);
   import div_pkg::*;

   localparam int W  = max3(WA, WB, WY);
   localparam int WM = min2(WA, WB);
   localparam int KM = min2(WM, WY);
   localparam int CW = (W > 1) ? $clog2(W) : 1;
   localparam int LW = $clog2(W + 3);

   generate
      if (WA < 1 || WB < 1 || WY < 1) begin : g_bad_width
         $error("seq_divider: every width must be at least 1");
      end
      if (W < 2) begin : g_bad_common
         $error("seq_divider: working width must be at least 2");
      end
   endgenerate

   div_state_e    state;
   logic [CW-1:0] cnt;
   logic          accept;
   logic          p_signed, p_aneg, p_bneg, p_bzero;
   logic [W-1:0]  p_amag, p_bmag;
   logic          signed_q, a_neg_q, b_neg_q, b_zero_q, want_rem_q;
   logic [KM-1:0] a_low_q;
   logic [W-1:0]  quo_mag, rem_mag;
   logic [WY-1:0] fix_res;
   logic [WY-1:0] result_q;
   logic          done_q;

   assign accept = start && (state == ST_IDLE);   // R10

   div_operand_prep #(.WA(WA), .WB(WB), .W(W)) i_prep (
      .a_in        (a_in),
      .b_in        (b_in),
      .a_sgn       (a_signed),
      .b_sgn       (b_signed),
      .signed_mode (p_signed),
      .a_neg       (p_aneg),
      .b_neg       (p_bneg),
      .b_zero      (p_bzero),
      .a_mag       (p_amag),
      .b_mag       (p_bmag)
   );

   div_restore_core #(.W(W)) i_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .step     (state == ST_RUN),
      .dividend (p_amag),
      .divisor  (p_bmag),
      .quo      (quo_mag),
      .rem      (rem_mag)
   );

   div_result_fix #(.WA(WA), .WY(WY), .W(W), .KM(KM)) i_fix (
      .quo_mag     (quo_mag),
      .rem_mag     (rem_mag),
      .want_rem    (want_rem_q),
      .signed_mode (signed_q),
      .a_neg       (a_neg_q),
      .b_neg       (b_neg_q),
      .b_zero      (b_zero_q),
      .a_low       (a_low_q),
      .res         (fix_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         signed_q   <= 1'b0;
         a_neg_q    <= 1'b0;
         b_neg_q    <= 1'b0;
         b_zero_q   <= 1'b0;
         want_rem_q <= 1'b0;
         a_low_q    <= '0;
         result_q   <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state      <= ST_RUN;
                  cnt        <= CW'(W - 1);
                  signed_q   <= p_signed;
                  a_neg_q    <= p_aneg;
                  b_neg_q    <= p_bneg;
                  b_zero_q   <= p_bzero;
                  want_rem_q <= want_rem;
                  a_low_q    <= a_in[KM-1:0];
               end
            end
            ST_RUN: begin
               // the zero divisor runs the same count (R8)
               if (cnt == '0) state <= ST_FIX;
               else           cnt   <= cnt - 1'b1;
            end
            ST_FIX: begin
               result_q <= fix_res;
               done_q   <= 1'b1;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (state != ST_IDLE);
   assign done   = done_q;
   assign result = result_q;

   // latency watch: edges since the accepting edge
   logic [LW-1:0] lat_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_cnt <= '0;
      else if (accept) lat_cnt <= '0;
      else if (busy)   lat_cnt <= lat_cnt + LW'(1);
   end

   assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_cnt == LW'(W + 1)));

   assert_idle_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

   assert_capture_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(a_low_q) && $stable(want_rem_q) && $stable(signed_q) && $stable(b_zero_q)));

   assert_sdiv_zero_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && b_zero_q && !want_rem_q && signed_q && !a_neg_q) |-> (result == '1));

endmodule

// File: tb/test_seq_divider.sv
module test_seq_divider;

   localparam int WA = 4;
   localparam int WB = 4;
   localparam int WY = 6;
   localparam int W  = 6;
   localparam int KM = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          a_signed = 1'b0;
   logic          b_signed = 1'b0;
   logic          want_rem = 1'b0;
   logic [WA-1:0] a_in = '0;
   logic [WB-1:0] b_in = '0;
   logic          busy;
   logic          done;
   logic [WY-1:0] result;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #10 clk = ~clk;   // 50 MHz

   seq_divider #(.WA(WA), .WB(WB), .WY(WY)) i_seq_divider (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .a_signed (a_signed),
      .b_signed (b_signed),
      .want_rem (want_rem),
      .a_in     (a_in),
      .b_in     (b_in),
      .busy     (busy),
      .done     (done),
      .result   (result)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         checks++;
         errors++;
         $display("FAIL R8 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // behavioural reference from the requirements
   function automatic logic [WY-1:0] ref_res(input logic [WA-1:0] a, input logic [WB-1:0] b,
                                             input bit as, input bit bs, input bit rm);
      bit sm;
      int ai, bi, v;
      sm = as & bs;
      ai = sm ? int'($signed(a)) : int'(a);
      bi = sm ? int'($signed(b)) : int'(b);
      if (b == '0) begin
         if (rm)      v = sm ? int'($signed(a[KM-1:0])) : int'(a[KM-1:0]);
         else if (sm) v = (ai < 0) ? 1 : -1;
         else         v = (1 << WA) - 1;
      end else begin
         v = rm ? (ai % bi) : (ai / bi);
      end
      return WY'(v);
   endfunction

   function automatic string tag_of(input logic [WB-1:0] b, input bit as, input bit bs, input bit rm);
      if (b == '0)     return rm ? "R7 mod-zero" : ((as && bs) ? "R6 sdiv-zero" : "R5 udiv-zero");
      if (as != bs)    return "R1 mixed-flags";
      if (as && bs)    return "R3 signed";
      return "R2 R4 unsigned";
   endfunction

   task automatic run_op(input logic [WA-1:0] a, input logic [WB-1:0] b,
                         input bit as, input bit bs, input bit rm, input bit poke);
      logic [WY-1:0] exp;
      string tg;
      exp = ref_res(a, b, as, bs, rm);
      tg  = tag_of(b, as, bs, rm);
      @(negedge clk);
      a_in = a; b_in = b; a_signed = as; b_signed = bs; want_rem = rm;
      start = 1'b1;
      for (int n = 1; n <= W + 2; n++) begin
         @(negedge clk);
         start = 1'b0;
         if (poke && n == 2) begin
            // R10: request while busy, with altered inputs
            start = 1'b1;
            a_in = ~a; b_in = b + 1'b1; want_rem = ~rm; a_signed = ~as;
         end
         check("R8 busy", 32'(busy), 32'(n <= W + 1));
         check("R8 done", 32'(done), 32'(n == W + 2));
      end
      check(poke ? "R10 ignored start" : tg, 32'(result), 32'(exp));
      if (poke) begin
         @(negedge clk);
         check("R9 done pulse", 32'(done), 32'd0);
         check("R9 result hold", 32'(result), 32'(exp));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11
      check("R11 busy", 32'(busy), 32'd0);
      check("R11 done", 32'(done), 32'd0);
      check("R11 result", 32'(result), 32'd0);
      rst_n = 1'b1;

      // corners first: most negative by -1, zero divisors
      run_op(4'h8, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0);   // R3: -8/-1 = 8
      run_op(4'h8, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0);   // R6: negative dividend -> 1
      run_op(4'h3, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0);   // R6: all ones
      run_op(4'h9, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0);   // R5: 0x0F
      run_op(4'hA, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0);   // R7: sign-extended 0x3A
      run_op(4'hA, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0);   // R7/R1: zero-extended 0x0A
      run_op(4'hD, 4'h2, 1'b1, 1'b1, 1'b1, 1'b1);   // R10 with hold check

      // exhaustive sweep: sc 0 unsigned, 1 signed, 2/3 mixed flags (R1)
      for (int sc = 0; sc < 4; sc++) begin
         for (int ai = 0; ai < 16; ai++) begin
            for (int bi = 0; bi < 16; bi++) begin
               for (int rm = 0; rm < 2; rm++) begin
                  if (sc < 2 || (ai % 3 == 0)) begin
                     run_op(WA'(ai), WB'(bi), sc == 1 || sc == 2, sc == 1 || sc == 3,
                            rm[0], (ai == 7 && bi == 5));
                  end
               end
            end
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule